// File: doc/BRIEF.md
# Multi-Mode Module Clock Enable Controller

This block decides whether one module clock runs. The decision comes from one of three sources. The first is a software bit written through a small register interface. The second is a vote over the low-power modes of two CPU domains, each of which is Run, Wait, Stop or Suspend. The third is a bitmap indexed by the active 4-bit system setpoint, overridden by a dedicated bit while system standby is asserted.

The result is registered as `clkEn`. It is then captured on the falling clock edge and ANDed with the clock to give a glitch-free `gatedClk`. Configuration is written one word at a time through `wrEn`, `wrAddr` and `wrData`. The CPU-mode enable, the owner mask and the setpoint-mode enable share one word, so the selection of source and owners changes in a single write.

Top module: `mclk_gate_ctrl`

## Requirements
- R1: While `rstN` is low, and immediately after it rises, `clkEn` and `gatedClk` are 0. All configuration fields are 0, which selects software mode with the direct bit cleared.
- R2: `clkEn` is a register. At each rising edge it takes the value decided from the configuration held before that edge and the inputs sampled at that edge. A write therefore shows on `clkEn` one edge after the edge that stores it. In software mode, `clkEn` follows the direct bit.
- R3: A write takes place on a rising edge with `wrEn` high, and `wrAddr` selects the word. Address 0: bit 0 is the direct bit. Address 1: bit 0 enables CPU-mode control, bits 2:1 are the owner mask, and bit 3 enables setpoint control. Address 2: bits 2:0 are the domain 0 level and bits 6:4 are the domain 1 level. Address 3: bits 15:0 are the setpoint mask and bit 16 is the standby state.
- R4: In CPU-mode control, owner mask bit 0 makes domain 0 an owner and bit 1 makes domain 1 an owner. A mask of 1 means domain 0, 2 means domain 1 and 3 means both. Domain modes arrive on `cpuMode`: domain 0 on bits 1:0 and domain 1 on bits 3:2, coded Run=0, Wait=1, Stop=2, Suspend=3.
- R5: A level gives the deepest mode in which an owner keeps the clock on. 0 means always off, 1 means Run, 2 means Run or Wait, 3 means Run, Wait or Stop, and 4 means all modes. Values 5 to 7 act as 4.
- R6: When both domains own the clock, it is on if either owner's mode satisfies its own level.
- R7: In CPU-mode control, an owner mask of 0 keeps `clkEn` at 0.
- R8: In setpoint control with standby low, `clkEn` equals the bit of the setpoint mask selected by `setpoint`.
- R9: In setpoint control with `sysStandby` high, `clkEn` equals the standby state bit, whatever the mask holds.
- R10: When both hardware controls are enabled, setpoint control decides.
- R11: `gatedClk` is `clk` ANDed with `clkEn` as captured at the preceding falling edge. It is high during each high clock phase that follows a cycle with `clkEn` set.
- R12: While either hardware control is enabled, the direct bit has no effect on `clkEn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the clock that is gated |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register word select |
| wrData | input | DATA_W | Write data |
| cpuMode | input | 4 | Current mode of domain 0 (bits 1:0) and domain 1 (bits 3:2) |
| setpoint | input | SP_W | Active system setpoint index |
| sysStandby | input | 1 | System standby indication |
| clkEn | output | 1 | Registered clock enable |
| gatedClk | output | 1 | Glitch-free gated clock |

## Verification
The properties assume that `cpuMode`, `setpoint`, `sysStandby` and the write port are synchronous to `clk` and change only away from the rising edge. They also assume that reset is applied at a falling edge, so that the falling-edge enable capture and the rising-edge register agree on every sampled edge. The stimulus drives every input at a falling edge and holds it for at least one full cycle. It walks each domain through all four mode codes under several owner masks and level values, including 0, 4 and 7. It then sweeps all sixteen setpoints and toggles standby with both standby state values.

// File: rtl/cg_pkg.sv
package cg_pkg;

  localparam int CG_NUM_DOM   = 2;
  localparam int CG_MODE_W    = 2;
  localparam int CG_LVL_W     = 3;
  localparam int CG_ADDR_W    = 2;
  localparam int LEVEL_STRIDE = 4;
  localparam int AUTH_CPU_BIT = 0;
  localparam int AUTH_OWN_LSB = 1;
  localparam int AUTH_SP_BIT  = AUTH_OWN_LSB + CG_NUM_DOM;

  typedef enum logic [CG_MODE_W-1:0] {
    MODE_RUN     = 2'd0,
    MODE_WAIT    = 2'd1,
    MODE_STOP    = 2'd2,
    MODE_SUSPEND = 2'd3
  } cpuMode_e;

  typedef enum logic [1:0] {
    SRC_DIRECT = 2'd0,
    SRC_CPU    = 2'd1,
    SRC_SETPT  = 2'd2
  } srcSel_e;

  typedef enum logic [CG_ADDR_W-1:0] {
    ADDR_DIRECT = 2'd0,
    ADDR_AUTH   = 2'd1,
    ADDR_LEVEL  = 2'd2,
    ADDR_SETPT  = 2'd3
  } regAddr_e;

  typedef struct packed {
    srcSel_e               selSrc;
    logic [CG_NUM_DOM-1:0] ownerMask;
    logic                  directOn;
    logic                  standbyOn;
    logic                  ldLevel;
    logic                  ldMask;
  } cgCtl_t;

endpackage

// File: rtl/cg_ctrl.sv
module cg_ctrl
  import cg_pkg::*;
#(
  parameter int NUM_SP = 16,
  parameter int DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [CG_ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0]    wrData,
  output cgCtl_t               ctl
);

  regAddr_e              addrSel;
  logic                  directQ;
  logic                  cpuEnQ;
  logic                  spEnQ;
  logic                  standbyQ;
  logic [CG_NUM_DOM-1:0] ownerQ;
  logic                  wrDataUnused;

  assign addrSel      = regAddr_e'(wrAddr);
  assign wrDataUnused = ^wrData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      directQ  <= 1'b0;
      cpuEnQ   <= 1'b0;
      spEnQ    <= 1'b0;
      standbyQ <= 1'b0;
      ownerQ   <= '0;
    end else if (wrEn) begin
      case (addrSel)
        ADDR_DIRECT: directQ <= wrData[0];
        ADDR_AUTH: begin
          cpuEnQ <= wrData[AUTH_CPU_BIT];
          ownerQ <= wrData[AUTH_OWN_LSB +: CG_NUM_DOM];
          spEnQ  <= wrData[AUTH_SP_BIT];
        end
        ADDR_SETPT: standbyQ <= wrData[NUM_SP];
        default: ;
      endcase
    end
  end

  always_comb begin
    if (spEnQ)       ctl.selSrc = SRC_SETPT;
    else if (cpuEnQ) ctl.selSrc = SRC_CPU;
    else             ctl.selSrc = SRC_DIRECT;
    ctl.ownerMask = ownerQ;
    ctl.directOn  = directQ;
    ctl.standbyOn = standbyQ;
    ctl.ldLevel   = wrEn && (addrSel == ADDR_LEVEL);
    ctl.ldMask    = wrEn && (addrSel == ADDR_SETPT);
  end

endmodule

// File: rtl/cg_datapath.sv
module cg_datapath
  import cg_pkg::*;
#(
  parameter int NUM_SP = 16,
  parameter int DATA_W = 32,
  localparam int SP_W  = $clog2(NUM_SP)
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  cgCtl_t                           ctl,
  input  logic [DATA_W-1:0]                wrData,
  input  logic [CG_NUM_DOM*CG_MODE_W-1:0]  cpuMode,
  input  logic [SP_W-1:0]                  setpoint,
  input  logic                             sysStandby,
  output logic                             clkEn
);

  logic [NUM_SP-1:0]     maskQ;
  logic [CG_NUM_DOM-1:0] domOn;
  logic                  cpuVote;
  logic                  spVote;
  logic                  nextEn;
  logic                  wrDataUnused;

  assign wrDataUnused = ^wrData;

  for (genvar d = 0; d < CG_NUM_DOM; d++) begin : g_dom
    logic [CG_LVL_W-1:0] levelQ;
    cpuMode_e            modeD;

    assign modeD = cpuMode_e'(cpuMode[d*CG_MODE_W +: CG_MODE_W]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            levelQ <= '0;
      else if (ctl.ldLevel) levelQ <= wrData[d*LEVEL_STRIDE +: CG_LVL_W];
    end

    // an owner keeps the clock while its mode is shallower than its level
    assign domOn[d] = ctl.ownerMask[d] && (CG_LVL_W'(modeD) < levelQ);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           maskQ <= '0;
    else if (ctl.ldMask) maskQ <= wrData[NUM_SP-1:0];
  end

  assign cpuVote = |domOn;
  assign spVote  = sysStandby ? ctl.standbyOn : maskQ[setpoint];

  always_comb begin
    case (ctl.selSrc)
      SRC_SETPT: nextEn = spVote;
      SRC_CPU:   nextEn = cpuVote;
      default:   nextEn = ctl.directOn;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) clkEn <= 1'b0;
    else       clkEn <= nextEn;
  end

endmodule

// File: rtl/cg_gate.sv
module cg_gate (
  input  logic clk,
  input  logic rstN,
  input  logic en,
  output logic enQ,
  output logic gatedClk
);

  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) enQ <= 1'b0;
    else       enQ <= en;
  end

  assign gatedClk = clk & enQ;

endmodule

// File: rtl/mclk_gate_ctrl.sv
module mclk_gate_ctrl
  import cg_pkg::*;
#(
  parameter int NUM_SP = 16,
  parameter int DATA_W = 32,
  localparam int SP_W  = $clog2(NUM_SP)
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            wrEn,
  input  logic [CG_ADDR_W-1:0]            wrAddr,
  input  logic [DATA_W-1:0]               wrData,
  input  logic [CG_NUM_DOM*CG_MODE_W-1:0] cpuMode,
  input  logic [SP_W-1:0]                 setpoint,
  input  logic                            sysStandby,
  output logic                            clkEn,
  output logic                            gatedClk
);

  cgCtl_t ctlBus;
  logic   gateEnQ;

  cg_ctrl #(.NUM_SP(NUM_SP), .DATA_W(DATA_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .ctl(ctlBus)
  );

  cg_datapath #(.NUM_SP(NUM_SP), .DATA_W(DATA_W)) i_datapath (
    .clk(clk), .rstN(rstN), .ctl(ctlBus), .wrData(wrData),
    .cpuMode(cpuMode), .setpoint(setpoint), .sysStandby(sysStandby),
    .clkEn(clkEn)
  );

  cg_gate i_gate (
    .clk(clk), .rstN(rstN), .en(clkEn), .enQ(gateEnQ), .gatedClk(gatedClk)
  );

endmodule

// File: rtl/mclk_gate_chk.sv
module mclk_gate_chk
  import cg_pkg::*;
(
  input logic   clk,
  input logic   rstN,
  input logic   sysStandby,
  input logic   clkEn,
  input logic   gateEnQ,
  input cgCtl_t ctl
);

  // R2
  direct_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.selSrc == SRC_DIRECT |=> clkEn == $past(ctl.directOn));

  // R7
  no_owner_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.selSrc == SRC_CPU && ctl.ownerMask == '0) |=> !clkEn);

  // R9
  standby_override_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.selSrc == SRC_SETPT && sysStandby) |=> clkEn == $past(ctl.standbyOn));

  // R11
  gate_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    gateEnQ == clkEn);

endmodule

bind mclk_gate_ctrl mclk_gate_chk i_chk (
  .clk(clk), .rstN(rstN), .sysStandby(sysStandby), .clkEn(clkEn),
  .gateEnQ(gateEnQ), .ctl(ctlBus)
);

// File: tb/test_mclk_gate_ctrl.sv
module test_mclk_gate_ctrl;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [3:0]  cpuMode = '0;
  logic [3:0]  setpoint = '0;
  logic        sysStandby = 1'b0;
  logic        clkEn;
  logic        gatedClk;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // reference state
  bit        mDirect, mCpuEn, mSpEn, mStandby;
  bit [1:0]  mOwner;
  int        mLvl0, mLvl1;
  bit [15:0] mMask;
  bit        expEn = 0;
  bit        expGate = 0;

  always #5 clk = ~clk;

  mclk_gate_ctrl i_mclk_gate_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .cpuMode(cpuMode), .setpoint(setpoint), .sysStandby(sysStandby),
    .clkEn(clkEn), .gatedClk(gatedClk)
  );

  function automatic bit refEval();
    int m0 = int'(cpuMode[1:0]);
    int m1 = int'(cpuMode[3:2]);
    if (mSpEn) return sysStandby ? mStandby : mMask[setpoint];
    if (mCpuEn) return (mOwner[0] && m0 < mLvl0) || (mOwner[1] && m1 < mLvl1);
    return mDirect;
  endfunction

  function automatic string tagNow();
    if (!rstN) return "R1";
    if (mSpEn) return sysStandby ? "R9" : "R8";
    if (mCpuEn) return (mOwner == 0) ? "R7" : (mOwner == 3) ? "R6" : "R4";
    return "R2";
  endfunction

  task automatic check(string tag, bit act, bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mDirect = 0; mCpuEn = 0; mSpEn = 0; mStandby = 0;
      mOwner = 0; mLvl0 = 0; mLvl1 = 0; mMask = 0; expEn = 0;
    end else begin
      expEn = refEval();
      if (wrEn) begin
        case (wrAddr)
          2'd0: mDirect = wrData[0];
          2'd1: begin mCpuEn = wrData[0]; mOwner = wrData[2:1]; mSpEn = wrData[3]; end
          2'd2: begin mLvl0 = int'(wrData[2:0]); mLvl1 = int'(wrData[6:4]); end
          default: begin mMask = wrData[15:0]; mStandby = wrData[16]; end
        endcase
      end
    end
  end

  // every cycle: registered enable against the reference
  always @(negedge clk) begin
    if (!done) check(tagNow(), clkEn, expEn);
    expGate = rstN ? expEn : 1'b0;
  end

  // every high phase: gated clock against the captured enable (R11)
  always @(posedge clk) begin
    #2;
    if (!done) check("R11", gatedClk, expGate);
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); wrEn = 1; wrAddr = a; wrData = d;
    @(negedge clk); wrEn = 0; wrData = '0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic setModes(input int m0, input int m1);
    @(negedge clk); cpuMode = {2'(m1), 2'(m0)};
    settle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", clkEn, 1'b0);
    check("R1", gatedClk, 1'b0);
    rstN = 1;
    @(negedge clk);
    check("R1", clkEn, 1'b0);

    // software mode
    wr(0, 32'h1); settle();
    check("R2", clkEn, 1'b1);
    @(posedge clk); #2; check("R11", gatedClk, 1'b1); @(negedge clk);
    wr(0, 32'h0); settle();
    check("R2", clkEn, 1'b0);
    @(posedge clk); #2; check("R11", gatedClk, 1'b0); @(negedge clk);

    // CPU-mode control, domain 0 level Run only, domain 1 up to Stop
    wr(2, 32'h31);
    wr(1, 32'h3);
    for (int m = 0; m < 4; m++) begin
      setModes(m, 0);
      check((m == 0) ? "R4" : "R5", clkEn, m == 0);
    end
    // direct bit ignored in hardware mode, domain 0 suspended
    wr(0, 32'h1); settle();
    check("R12", clkEn, 1'b0);
    wr(0, 32'h0);

    wr(1, 32'h5);
    for (int m = 0; m < 4; m++) begin
      setModes(0, m);
      check("R5", clkEn, m < 3);
    end

    // shared clock
    wr(1, 32'h7);
    setModes(3, 3); check("R6", clkEn, 1'b0);
    setModes(0, 3); check("R6", clkEn, 1'b1);
    setModes(3, 1); check("R6", clkEn, 1'b1);

    // empty owner mask
    wr(1, 32'h1);
    setModes(0, 0); check("R7", clkEn, 1'b0);

    // level 0 and levels above 4
    wr(2, 32'h70); wr(1, 32'h7);
    setModes(0, 3); check("R5", clkEn, 1'b1);
    wr(2, 32'h40); settle(); check("R5", clkEn, 1'b1);
    wr(2, 32'h00);
    setModes(0, 0); check("R5", clkEn, 1'b0);
    check("R3", clkEn, 1'b0);

    // setpoint control with empty owner mask also enabled
    wr(3, 32'h0000A5A5);
    wr(1, 32'h9);
    for (int s = 0; s < 16; s++) begin
      @(negedge clk); setpoint = 4'(s);
      settle();
      check((s == 0) ? "R10" : "R8", clkEn, 16'hA5A5 >> s);
    end

    // standby override
    @(negedge clk); setpoint = 0; sysStandby = 1;
    settle(); check("R9", clkEn, 1'b0);
    wr(3, 32'h00010000); settle();
    check("R9", clkEn, 1'b1);
    @(negedge clk); sysStandby = 0;
    settle(); check("R8", clkEn, 1'b0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(50000 * 10);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule